// File: doc/BRIEF.md
# Cascadable Column Data Loader

This block is the digital front end of one segment-driver stage for a dot-matrix display. It takes one row of column data from a controller over a parallel bus that is either 4 or 8 bits wide. The data is paced by a data clock, and the stage fills a 160-column data latch from it. A falling edge on the latch pulse copies the captured row into a line latch, and the line latch sets the per-column output level codes. The analog drivers turn those codes into panel voltages.

Stages share the data bus and form a chain through their enable pins. A stage starts capturing once its enable input has been seen low. When it has taken exactly 160 bits it stops and drives its enable output low, which selects the next stage. A direction input sets two things: which enable pin is the input and which is the output, and whether the row fills from the first column or from the last. A display-off input forces every output to the deselect level and clears the line latch, while capture into the data latch goes on.

All inputs are sampled by a single system clock. The falling edges of the data clock and of the latch pulse are found by edge detection, so the design is fully synchronous.

Top module: `col_loader`

## Requirements
- R1: After reset, both enable outputs are high, the line latch is zero and every level code is 2'b00.
- R2: With `wide_mode` high, each detected falling edge of `dclk` takes one byte from `din[7:0]`. Bit k of the i-th byte of the row is stream position 8*i+k.
- R3: With `wide_mode` low, each falling edge of `dclk` takes only `din[3:0]`. The first nibble forms bits 3:0 of a byte and the second forms bits 7:4. `din[7:4]` has no effect.
- R4: With `dir_fwd` high, stream position p goes to column p, the enable enters on `en_a_i` and leaves on `en_b_o`, and `en_a_o` stays high. With `dir_fwd` low, position p goes to column 159-p, the enable enters on `en_b_i` and leaves on `en_a_o`, and `en_b_o` stays high.
- R5: A stage captures only once its enable input has been seen low since the last latch pulse. It stays selected after that input returns high. Data beyond 160 bits is ignored until the next latch pulse.
- R6: The cycle in which the 160th bit is taken, the enable output goes low. It returns high on the next latch pulse falling edge.
- R7: On a detected falling edge of `lpulse`, the line latch takes the data latch contents. The levels show the new row from that cycle on.
- R8: While `blank_n` is low, every level code is 2'b00 and the line latch is cleared, but data is still captured into the data latch.
- R9: With `blank_n` high, the level code of column c is {`frame_inv`, line bit c}, placed at `levels[2c+1:2c]`.
- R10: The data latch is written one complete 16-bit group at a time. A partial group left when a latch pulse arrives is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dclk | input | 1 | Data clock; data taken on its falling edge |
| lpulse | input | 1 | Latch pulse; row transfer and restart on its falling edge |
| wide_mode | input | 1 | 1 = 8-bit bus, 0 = 4-bit bus |
| din | input | 8 | Parallel column data |
| dir_fwd | input | 1 | Fill direction and enable pin roles |
| en_a_i | input | 1 | Enable input on pin A (active low, used when dir_fwd=1) |
| en_b_i | input | 1 | Enable input on pin B (active low, used when dir_fwd=0) |
| en_a_o | output | 1 | Enable output on pin A (dir_fwd=0), else high |
| en_b_o | output | 1 | Enable output on pin B (dir_fwd=1), else high |
| blank_n | input | 1 | 0 = display off |
| frame_inv | input | 1 | Frame inversion input |
| levels | output | 320 | 2-bit level code per column |

## Verification
A wrong bit count or group pointer shows at the enable output within one data clock. The handoff arrives a byte early or late, and the downstream stage then captures a shifted stream. A fault in packing, group addressing or direction mapping stays hidden in the data latch until the next latch pulse. It then shows as misplaced or corrupted level codes in the columns affected. Display-off faults show within two system clocks as nonzero levels, or after blanking ends as stale rows that reappear.

// File: rtl/colld_pkg.sv
`timescale 1ns/1ps
package colld_pkg;
  // Stream position that feeds a given column for a fill direction.
  function automatic int unsigned stream_pos(int unsigned col, int unsigned ncols, bit fwd);
    return fwd ? col : (ncols - 1 - col);
  endfunction

  // Index of the 16-bit group holding a stream position.
  function automatic int unsigned group_of(int unsigned pos, int unsigned grp);
    return pos / grp;
  endfunction

  // Bit position inside its group.
  function automatic int unsigned bit_in_group(int unsigned pos, int unsigned grp);
    return pos % grp;
  endfunction
endpackage

// File: rtl/colld_fall_det.sv
`timescale 1ns/1ps
module colld_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sig;
  end

  assign fall = prev_q & ~sig;
endmodule

// File: rtl/colld_packer.sv
`timescale 1ns/1ps
module colld_packer #(
  parameter int GRP = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear,
  input  logic           take,
  input  logic           wide,
  input  logic [7:0]     din,
  output logic           grp_wr,
  output logic [GRP-1:0] grp_data
);
  localparam int BPG = GRP / 8;
  localparam int BCW = (BPG > 1) ? $clog2(BPG) : 1;

  logic [3:0]     nib_q;
  logic           nib_ph;
  logic [GRP-9:0] acc_q;
  logic [BCW-1:0] byte_cnt;
  logic [7:0]     byte_now;
  logic           byte_vld;

  always_comb begin
    byte_now = wide ? din : {din[3:0], nib_q};
    byte_vld = take & (wide | nib_ph);
    grp_wr   = byte_vld & (byte_cnt == BCW'(BPG - 1));
    grp_data = {byte_now, acc_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nib_q    <= '0;
      nib_ph   <= 1'b0;
      acc_q    <= '0;
      byte_cnt <= '0;
    end else if (clear) begin
      nib_ph   <= 1'b0;
      byte_cnt <= '0;
    end else if (take) begin
      if (!wide) begin
        nib_ph <= ~nib_ph;
        if (!nib_ph) nib_q <= din[3:0];
      end
      if (byte_vld) begin
        acc_q    <= (GRP-8)'({byte_now, acc_q} >> 8);
        byte_cnt <= grp_wr ? '0 : byte_cnt + BCW'(1);
      end
    end
  end
endmodule

// File: rtl/colld_select.sv
`timescale 1ns/1ps
module colld_select #(
  parameter int NGRP = 10,
  parameter int GW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lp_fall,
  input  logic          en_in,
  input  logic          grp_wr,
  output logic          cap_en,
  output logic [GW-1:0] grp_idx,
  output logic          done,
  output logic          en_out
);
  logic sel_q;

  assign cap_en = (sel_q | ~en_in) & ~done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= 1'b0;
      done    <= 1'b0;
      en_out  <= 1'b1;
      grp_idx <= '0;
    end else if (lp_fall) begin
      sel_q   <= 1'b0;
      done    <= 1'b0;
      en_out  <= 1'b1;
      grp_idx <= '0;
    end else begin
      if (!en_in && !done) sel_q <= 1'b1;
      if (grp_wr) begin
        if (grp_idx == GW'(NGRP - 1)) begin
          done   <= 1'b1;
          en_out <= 1'b0;
          sel_q  <= 1'b0;
        end else begin
          grp_idx <= grp_idx + GW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/colld_store.sv
`timescale 1ns/1ps
module colld_store #(
  parameter int NCOLS = 160,
  parameter int GRP   = 16,
  parameter int GW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lp_fall,
  input  logic             blank_n,
  input  logic             frame_inv,
  input  logic             fwd,
  input  logic             grp_wr,
  input  logic [GW-1:0]    grp_idx,
  input  logic [GRP-1:0]   grp_data,
  output logic [NCOLS-1:0] data_q,
  output logic [NCOLS-1:0] line_q,
  output logic [2*NCOLS-1:0] levels
);
  logic [NCOLS-1:0] data_d;

  for (genvar c = 0; c < NCOLS; c++) begin : g_col
    localparam int unsigned PF = colld_pkg::stream_pos(c, NCOLS, 1'b1);
    localparam int unsigned PR = colld_pkg::stream_pos(c, NCOLS, 1'b0);
    localparam int unsigned GF = colld_pkg::group_of(PF, GRP);
    localparam int unsigned GR = colld_pkg::group_of(PR, GRP);
    localparam int unsigned BF = colld_pkg::bit_in_group(PF, GRP);
    localparam int unsigned BR = colld_pkg::bit_in_group(PR, GRP);
    logic hit, nb;
    assign hit = grp_wr & (fwd ? (grp_idx == GW'(GF)) : (grp_idx == GW'(GR)));
    assign nb  = fwd ? grp_data[BF] : grp_data[BR];
    assign data_d[c] = hit ? nb : data_q[c];
    assign levels[2*c +: 2] = blank_n ? {frame_inv, line_q[c]} : 2'b00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      line_q <= '0;
    end else begin
      data_q <= data_d;
      if (!blank_n)     line_q <= '0;
      else if (lp_fall) line_q <= data_q;
    end
  end
endmodule

// File: rtl/col_loader.sv
`timescale 1ns/1ps
module col_loader #(
  parameter int NCOLS = 160,
  parameter int GRP   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dclk,
  input  logic               lpulse,
  input  logic               wide_mode,
  input  logic [7:0]         din,
  input  logic               dir_fwd,
  input  logic               en_a_i,
  input  logic               en_b_i,
  output logic               en_a_o,
  output logic               en_b_o,
  input  logic               blank_n,
  input  logic               frame_inv,
  output logic [2*NCOLS-1:0] levels
);
  localparam int NGRP = NCOLS / GRP;
  localparam int GW   = (NGRP > 1) ? $clog2(NGRP) : 1;

  // Named internal events, visible to the bound checker.
  logic             dclk_fall, lp_fall, take, cap_en;
  logic             grp_wr, done, en_out, en_in;
  logic [GW-1:0]    grp_idx;
  logic [GRP-1:0]   grp_data;
  logic [NCOLS-1:0] data_q, line_q;

  assign en_in  = dir_fwd ? en_a_i : en_b_i;
  assign en_a_o = dir_fwd ? 1'b1 : en_out;
  assign en_b_o = dir_fwd ? en_out : 1'b1;
  assign take   = dclk_fall & cap_en & ~lp_fall;

  colld_fall_det u_dclk_edge (.clk(clk), .rst_n(rst_n), .sig(dclk),   .fall(dclk_fall));
  colld_fall_det u_lp_edge   (.clk(clk), .rst_n(rst_n), .sig(lpulse), .fall(lp_fall));

  colld_packer #(.GRP(GRP)) u_pack (
    .clk(clk), .rst_n(rst_n), .clear(lp_fall), .take(take), .wide(wide_mode),
    .din(din), .grp_wr(grp_wr), .grp_data(grp_data)
  );

  colld_select #(.NGRP(NGRP), .GW(GW)) u_sel (
    .clk(clk), .rst_n(rst_n), .lp_fall(lp_fall), .en_in(en_in), .grp_wr(grp_wr),
    .cap_en(cap_en), .grp_idx(grp_idx), .done(done), .en_out(en_out)
  );

  colld_store #(.NCOLS(NCOLS), .GRP(GRP), .GW(GW)) u_store (
    .clk(clk), .rst_n(rst_n), .lp_fall(lp_fall), .blank_n(blank_n),
    .frame_inv(frame_inv), .fwd(dir_fwd), .grp_wr(grp_wr), .grp_idx(grp_idx),
    .grp_data(grp_data), .data_q(data_q), .line_q(line_q), .levels(levels)
  );
endmodule

// File: rtl/colld_chk.sv
`timescale 1ns/1ps
module colld_chk #(
  parameter int NCOLS = 160,
  parameter int GRP   = 16,
  parameter int GW    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lp_fall,
  input logic             blank_n,
  input logic             grp_wr,
  input logic [GW-1:0]    grp_idx,
  input logic             done,
  input logic             en_out,
  input logic [NCOLS-1:0] data_q,
  input logic [NCOLS-1:0] line_q
);
  localparam int NGRP = NCOLS / GRP;

  a_r6_lp_restores_en: assert property (@(posedge clk) disable iff (!rst_n)
    lp_fall |=> en_out);

  a_r6_done_lowers_en: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !en_out);

  a_r5_no_write_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !grp_wr);

  a_r7_lp_copies_row: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_fall && blank_n) |=> (line_q == $past(data_q)));

  a_r8_blank_clears_line: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_n |=> (line_q == '0));

  a_r10_group_index_range: assert property (@(posedge clk) disable iff (!rst_n)
    grp_idx < GW'(NGRP));
endmodule

bind col_loader colld_chk #(.NCOLS(NCOLS), .GRP(GRP), .GW(GW)) u_chk (
  .clk(clk), .rst_n(rst_n), .lp_fall(lp_fall), .blank_n(blank_n),
  .grp_wr(grp_wr), .grp_idx(grp_idx), .done(done), .en_out(en_out),
  .data_q(data_q), .line_q(line_q)
);

// File: tb/col_loader_test.sv
`timescale 1ns/1ps
module col_loader_test;
  localparam int NC = 160;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, dclk = 1'b0, lpulse = 1'b0, wide = 1'b1, dir_fwd = 1'b1;
  logic ctrl_en = 1'b1, blank_n = 1'b1, fr = 1'b0;
  logic [7:0] din = '0;
  logic a0i, b0i, a0o, b0o, a1o, b1o;
  logic [2*NC-1:0] lv0, lv1;

  assign a0i = dir_fwd ? ctrl_en : 1'b1;
  assign b0i = dir_fwd ? 1'b1 : ctrl_en;

  col_loader uut (.clk(clk), .rst_n(rst_n), .dclk(dclk), .lpulse(lpulse), .wide_mode(wide),
    .din(din), .dir_fwd(dir_fwd), .en_a_i(a0i), .en_b_i(b0i), .en_a_o(a0o), .en_b_o(b0o),
    .blank_n(blank_n), .frame_inv(fr), .levels(lv0));
  col_loader u_next (.clk(clk), .rst_n(rst_n), .dclk(dclk), .lpulse(lpulse), .wide_mode(wide),
    .din(din), .dir_fwd(dir_fwd), .en_a_i(b0o), .en_b_i(a0o), .en_a_o(a1o), .en_b_o(b1o),
    .blank_n(blank_n), .frame_inv(fr), .levels(lv1));

  int n_chk = 0, n_bad = 0;
  typedef struct { string tag; logic [2*NC-1:0] e0; logic [2*NC-1:0] e1; } item_t;
  item_t sb[$];

  // Reference state
  logic [NC-1:0] md [2];
  logic [NC-1:0] ml [2];
  logic [15:0] pend;
  int sidx = 0;
  bit msel = 0;

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  function automatic logic [2*NC-1:0] mk_lv(logic [NC-1:0] line);
    logic [2*NC-1:0] v = '0;
    for (int c = 0; c < NC; c++) v[2*c +: 2] = blank_n ? {fr, line[c]} : 2'b00;
    return v;
  endfunction

  // Driver side: push expected levels; the monitor compares them.
  task automatic expect_lv(string tag);
    item_t it;
    it.tag = tag; it.e0 = mk_lv(ml[0]); it.e1 = mk_lv(ml[1]);
    sb.push_back(it);
    repeat (3) @(negedge clk);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      wait (sb.size() != 0);
      @(negedge clk);
      it = sb.pop_front();
      n_chk += 2;
      if (lv0 !== it.e0) begin
        n_bad++; $display("FAIL %s stage0: actual %h expected %h", it.tag, lv0, it.e0);
      end
      if (lv1 !== it.e1) begin
        n_bad++; $display("FAIL %s stage1: actual %h expected %h", it.tag, lv1, it.e1);
      end
    end
  end

  // Reference model of capture: groups of 16 committed whole (R10).
  task automatic put_byte(logic [7:0] b);
    for (int k = 0; k < 8; k++) begin
      if (sidx < 2*NC) begin
        int st = sidx / NC;
        int p  = sidx % NC;
        pend[p % 16] = b[k];
        if (p % 16 == 15)
          for (int j = 0; j < 16; j++) begin
            int pp = p - 15 + j;
            md[st][dir_fwd ? pp : NC-1-pp] = pend[j];
          end
      end
      sidx++;
    end
  endtask

  task automatic pulse_dclk();
    dclk = 1'b1; repeat (2) @(negedge clk);
    dclk = 1'b0; repeat (2) @(negedge clk);
  endtask

  task automatic drive_byte(logic [7:0] b, logic [3:0] junk);
    if (wide) begin
      din = b; pulse_dclk();
    end else begin
      din = {junk, b[3:0]};  pulse_dclk();
      din = {~junk, b[7:4]}; pulse_dclk();
    end
    if (msel) put_byte(b);
  endtask

  task automatic chk_handoff(string tag, logic s0, logic s1);
    chk({tag, " stage0 out"},  dir_fwd ? b0o : a0o, s0);
    chk({tag, " stage0 idle"}, dir_fwd ? a0o : b0o, 1'b1);
    chk({tag, " stage1 out"},  dir_fwd ? b1o : a1o, s1);
  endtask

  task automatic row(int n, int seed, bit use_en, bit hand);
    msel = use_en;
    if (use_en) ctrl_en = 1'b0;
    for (int i = 0; i < n; i++) begin
      drive_byte(8'(i*37 + seed), 4'(i) ^ 4'hA);
      if (i == 0) ctrl_en = 1'b1;
      if (hand && i == 19) chk_handoff("R6 R4 after 160 bits", 1'b0, 1'b1);
      if (hand && i == 39) chk_handoff("R6 R4 after 320 bits", 1'b0, 1'b0);
    end
  endtask

  task automatic latch();
    lpulse = 1'b1; repeat (2) @(negedge clk);
    lpulse = 1'b0; repeat (3) @(negedge clk);
    for (int s = 0; s < 2; s++) ml[s] = blank_n ? md[s] : '0;
    sidx = 0; msel = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    for (int s = 0; s < 2; s++) begin md[s] = '0; ml[s] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 en_a_o stage0", a0o, 1'b1); chk("R1 en_b_o stage0", b0o, 1'b1);
    chk("R1 en_a_o stage1", a1o, 1'b1); chk("R1 en_b_o stage1", b1o, 1'b1);
    expect_lv("R1 reset levels");

    // R2 wide forward, with 2 extra bytes beyond 320 bits (R5)
    row(42, 5, 1, 1);
    latch();
    chk_handoff("R6 restored after latch", 1'b1, 1'b1);
    expect_lv("R2 R7 wide forward row");

    // R3 narrow forward; R9 frame inversion on both values
    wide = 1'b0;
    row(40, 91, 1, 1);
    latch();
    expect_lv("R3 narrow forward fr0");
    fr = 1'b1; repeat (2) @(negedge clk);
    expect_lv("R9 narrow forward fr1");

    // R4 reverse direction, wide then narrow
    dir_fwd = 1'b0; wide = 1'b1; fr = 1'b0;
    row(40, 17, 1, 1);
    latch();
    chk_handoff("R6 reverse restored", 1'b1, 1'b1);
    expect_lv("R4 wide reverse row");
    wide = 1'b0; fr = 1'b1;
    row(40, 200, 1, 1);
    latch();
    expect_lv("R4 R3 narrow reverse row");

    // R5 no enable: nothing captured, row repeats
    dir_fwd = 1'b1; wide = 1'b1;
    row(6, 77, 0, 0);
    chk_handoff("R5 unselected keeps enables", 1'b1, 1'b1);
    latch();
    expect_lv("R5 unselected stage ignores data");

    // R8 display off
    blank_n = 1'b0; repeat (2) @(negedge clk);
    ml[0] = '0; ml[1] = '0;
    expect_lv("R8 blank forces deselect");
    row(40, 140, 1, 0);
    latch();
    expect_lv("R8 latch while blank");
    blank_n = 1'b1; repeat (2) @(negedge clk);
    expect_lv("R8 line cleared after blank");
    latch();
    expect_lv("R8 data captured while blank");

    // R10 partial group dropped: stage1 gets only one byte
    row(21, 33, 1, 0);
    latch();
    expect_lv("R10 partial group dropped");

    repeat (4) @(negedge clk);
    wait (sb.size() == 0);
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule